// File: doc/BRIEF.md
# Set-Dueling Insertion Policy Selector

This block chooses, while the cache runs, which insertion policy the ordinary sets of a cache should use. A small group of sets is permanently tied to classic LRU insertion, where new lines enter at the most-recently-used position. A second group of the same size is permanently tied to bimodal insertion, where most new lines enter at the least-recently-used position. Every miss in either group moves one saturating selector counter. A miss in an LRU-tied set moves it up, and a miss in a bimodal-tied set moves it down. All other sets, the followers, take whichever policy the counter currently favours.

On each access the cache presents the set index and a miss strobe. In the same cycle, the block returns the insertion policy to apply to that set and a flag that says whether the set is one of the tied ones. The block needs no auxiliary tag directory and no extra bits in the tag entries. Its only state is the counter.

Top module: `set_duel_selector`

## Requirements
- R1: After reset the selector counter holds 512, so a follower access reports `ins_bimodal` = 1. Here 1 means bimodal insertion and 0 means classic LRU insertion.
- R2: A set is LRU-tied when index bits [9:5] equal bits [4:0]. For such a set, `set_tied` = 1 and `ins_bimodal` = 0, whatever the counter holds.
- R3: A set is bimodal-tied when index bits [9:5] equal the bitwise inverse of bits [4:0]. For such a set, `set_tied` = 1 and `ins_bimodal` = 1, whatever the counter holds.
- R4: Every other set is a follower. It reports `set_tied` = 0, and `ins_bimodal` = 1 exactly when the counter is 512 or more.
- R5: An access with `acc_valid` = 1 and `acc_miss` = 1 changes the counter. It adds one for an LRU-tied set and subtracts one for a bimodal-tied set.
- R6: The counter does not change for follower misses, for hits, or when `acc_valid` = 0.
- R7: The counter saturates. It stays at 1023 on further increments and at 0 on further decrements.
- R8: A counter change takes effect at the clock edge that ends the missing access. The policy reported in any cycle reflects only misses from earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_set | input | 10 | Set index of the access |
| acc_miss | input | 1 | The access missed |
| ins_bimodal | output | 1 | Policy for the indexed set: 1 bimodal, 0 classic LRU |
| set_tied | output | 1 | The indexed set is tied to a fixed policy |

## Verification
The assertions check on every cycle that the two tied groups never overlap and that a tied set always reports its own fixed policy. They also check the counter's one-step moves, that it holds when nothing should move it, and that it stays at its limits. Only the bench's scenarios can show the longer behaviour. That includes walking the counter into each limit and back out across the 512 threshold, and a follower's policy flipping exactly one cycle after the deciding miss. It also includes long mixed random traffic matching a counter model that is kept outside the design.

// File: rtl/sd_pkg.sv
// Shared types for the set-dueling selector.
// Assumes: policy encoding 0 = classic LRU insertion, 1 = bimodal insertion.
package sd_pkg;
    typedef enum logic {
        POL_LRU     = 1'b0,
        POL_BIMODAL = 1'b1
    } ins_pol_e;

    // Class of a set within the duel.
    typedef enum logic [1:0] {
        SET_FOLLOW  = 2'd0,
        SET_LEADLRU = 2'd1,
        SET_LEADBIP = 2'd2
    } set_class_e;
endpackage

// File: rtl/sd_set_classifier.sv
// Decides from the set index alone whether a set is tied to LRU, tied to
// bimodal insertion, or is a follower. The upper field [2L-1:L] is compared
// with the lower field [L-1:0]. Equal means LRU-tied; bitwise inverse means
// bimodal-tied. Assumes IDX_W >= 2*LEAD_W, which gives 2^LEAD_W sets per group.
module sd_set_classifier
    import sd_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int LEAD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    output set_class_e       set_class
);
    logic [LEAD_W-1:0] hi_field;
    logic [LEAD_W-1:0] lo_field;
    logic              match_lru;
    logic              match_bip;

    assign hi_field = set_idx[2*LEAD_W-1:LEAD_W];
    assign lo_field = set_idx[LEAD_W-1:0];

    // Field comparison for the two tied groups.
    always_comb begin
        match_lru = (hi_field == lo_field);
        match_bip = (hi_field == ~lo_field);
    end

    // Encode the class; the two matches can never both hold.
    always_comb begin
        if (match_lru)      set_class = SET_LEADLRU;
        else if (match_bip) set_class = SET_LEADBIP;
        else                set_class = SET_FOLLOW;
    end

    // R2/R3: a set index never belongs to both tied groups.
    assert_groups_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_lru, match_bip}));
endmodule

// File: rtl/sd_psel_counter.sv
// Saturating up/down selector counter. It resets to the midpoint
// 2^(CNT_W-1). inc and dec are never both high, because they come from
// disjoint set groups.
module sd_psel_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;
    localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(1) << (CNT_W - 1);

    logic at_max;
    logic at_min;

    assign at_max = (cnt == CNT_MAX);
    assign at_min = (cnt == CNT_MIN);

    // Midpoint on reset, then saturating single steps.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= CNT_MID;
        else if (inc && !at_max)   cnt <= cnt + CNT_W'(1);
        else if (dec && !at_min)   cnt <= cnt - CNT_W'(1);
    end

    assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !at_max) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !at_min) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> $stable(cnt));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max) |=> (cnt == CNT_MAX));

    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && at_min) |=> (cnt == CNT_MIN));

    assert_no_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));
endmodule

// File: rtl/set_duel_selector.sv
// Top of the set-dueling policy selector. It classifies the accessed set,
// steers misses from tied sets into the selector counter, and returns the
// insertion policy for the accessed set in the same cycle. Counter changes
// take effect at the next edge. Assumes at most one access per cycle.
module set_duel_selector
    import sd_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int LEAD_W = 5,
    parameter int CNT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_set,
    input  logic             acc_miss,
    output logic             ins_bimodal,
    output logic             set_tied
);
    set_class_e       cls;
    logic [CNT_W-1:0] psel;
    logic             cnt_inc;
    logic             cnt_dec;
    ins_pol_e         follow_pol;
    ins_pol_e         chosen_pol;

    sd_set_classifier #(.IDX_W(IDX_W), .LEAD_W(LEAD_W)) u_class (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (acc_set),
        .set_class (cls)
    );

    // Only valid misses in tied sets move the counter.
    always_comb begin
        cnt_inc = acc_valid && acc_miss && (cls == SET_LEADLRU);
        cnt_dec = acc_valid && acc_miss && (cls == SET_LEADBIP);
    end

    sd_psel_counter #(.CNT_W(CNT_W)) u_psel (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .dec   (cnt_dec),
        .cnt   (psel)
    );

    // Followers take bimodal once the counter reaches the midpoint.
    always_comb follow_pol = psel[CNT_W-1] ? POL_BIMODAL : POL_LRU;

    // Tied sets override the follower policy.
    always_comb begin
        case (cls)
            SET_LEADLRU: chosen_pol = POL_LRU;
            SET_LEADBIP: chosen_pol = POL_BIMODAL;
            default:     chosen_pol = follow_pol;
        endcase
    end

    assign ins_bimodal = (chosen_pol == POL_BIMODAL);
    assign set_tied    = (cls != SET_FOLLOW);

    assert_lru_tied_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == SET_LEADLRU) |-> (set_tied && !ins_bimodal));

    assert_bip_tied_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == SET_LEADBIP) |-> (set_tied && ins_bimodal));

    // R8: a follower's policy can change only after a counting miss.
    assert_follow_change_needs_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_inc && !cnt_dec) |=> $stable(follow_pol));
endmodule

// File: tb/set_duel_selector_tb.sv
`timescale 1ns/1ps
module set_duel_selector_tb;
    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_set = '0;
    logic             acc_miss = 1'b0;
    logic             ins_bimodal;
    logic             set_tied;

    int checks = 0;
    int errors = 0;
    int model  = 512;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    set_duel_selector u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_set     (acc_set),
        .acc_miss    (acc_miss),
        .ins_bimodal (ins_bimodal),
        .set_tied    (set_tied)
    );

    // 1 = LRU-tied (R2), 2 = bimodal-tied (R3), 0 = follower (R4).
    function automatic int set_kind(input logic [9:0] s);
        if (s[9:5] == s[4:0])  return 1;
        if (s[9:5] == ~s[4:0]) return 2;
        return 0;
    endfunction

    function automatic logic [9:0] lru_set(input logic [4:0] v);
        return {v, v};
    endfunction

    function automatic logic [9:0] bip_set(input logic [4:0] v);
        return {~v, v};
    endfunction

    function automatic logic [9:0] follow_set();
        logic [9:0] s;
        do s = 10'($urandom); while (set_kind(s) != 0);
        return s;
    endfunction

    task automatic check(input string tag, input logic got_b, input logic got_t,
                         input logic exp_b, input logic exp_t);
        checks++;
        if (got_b !== exp_b || got_t !== exp_t) begin
            errors++;
            $display("FAIL %s set=%0d actual bimodal=%b tied=%b expected bimodal=%b tied=%b",
                     tag, acc_set, got_b, got_t, exp_b, exp_t);
        end
    endtask

    // Drive one access, check the same-cycle outputs, then update the model.
    task automatic access(input logic [9:0] s, input logic miss, input logic vld,
                          input string tag_follow);
        int k;
        @(negedge clk);
        acc_set = s; acc_miss = miss; acc_valid = vld;
        #1;
        k = set_kind(s);
        if (k == 1)      check("R2", ins_bimodal, set_tied, 1'b0, 1'b1);
        else if (k == 2) check("R3", ins_bimodal, set_tied, 1'b1, 1'b1);
        else             check(tag_follow, ins_bimodal, set_tied, model >= 512, 1'b0);
        @(posedge clk);
        if (vld && miss) begin
            if (k == 1 && model < 1023) model++;
            if (k == 2 && model > 0)    model--;
        end
    endtask

    task automatic probe(input string tag);
        access(follow_set(), 1'b0, 1'b1, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: after reset the counter is 512, so followers get bimodal.
        probe("R1");

        // R2/R3: tied sets report fixed policy regardless of the counter.
        access(lru_set(5'd0), 1'b0, 1'b1, "R4");
        access(bip_set(5'd0), 1'b0, 1'b1, "R4");
        access(lru_set(5'd31), 1'b0, 1'b1, "R4");

        // R8: a bimodal-tied miss at 512 reaches a follower one cycle later.
        access(bip_set(5'd7), 1'b1, 1'b1, "R4");
        probe("R8");
        access(lru_set(5'd9), 1'b1, 1'b1, "R4");
        probe("R8");

        // R6: follower misses, hits and idle cycles leave the counter alone.
        access(bip_set(5'd3), 1'b1, 1'b1, "R4");
        for (int i = 0; i < 20; i++) access(follow_set(), 1'b1, 1'b1, "R6");
        for (int i = 0; i < 20; i++) access(lru_set(5'(i)), 1'b0, 1'b1, "R6");
        for (int i = 0; i < 20; i++) access(lru_set(5'(i)), 1'b1, 1'b0, "R6");
        probe("R6");
        access(lru_set(5'd3), 1'b1, 1'b1, "R5");
        probe("R5");

        // R7: saturate high, then walk down; a wrap would break the crossing.
        for (int i = 0; i < 600; i++) access(lru_set(5'(i)), 1'b1, 1'b1, "R5");
        for (int i = 0; i < 511; i++) access(bip_set(5'(i)), 1'b1, 1'b1, "R7");
        probe("R7");
        access(bip_set(5'd1), 1'b1, 1'b1, "R7");
        probe("R7");

        // R7: saturate low, then walk up.
        for (int i = 0; i < 600; i++) access(bip_set(5'(i)), 1'b1, 1'b1, "R5");
        for (int i = 0; i < 511; i++) access(lru_set(5'(i)), 1'b1, 1'b1, "R7");
        probe("R7");
        access(lru_set(5'd2), 1'b1, 1'b1, "R7");
        probe("R7");

        // Mixed random traffic against the model (R4, R5).
        for (int i = 0; i < 3000; i++) begin
            int pick = $urandom_range(0, 2);
            logic [9:0] s;
            if (pick == 0)      s = lru_set(5'($urandom));
            else if (pick == 1) s = bip_set(5'($urandom));
            else                s = follow_set();
            access(s, 1'($urandom), ($urandom_range(0, 7) != 0), "R4");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule